// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block produces the single level-sensitive interrupt line of a display controller. It combines two sources. The first is a vertical-blank event, gated by a three-state pending tracker and by enable bits in two control registers. The second is a set of engine completion events, such as command FIFO drained, 3D FIFO drained and 3D render finished. Each engine event is latched into a status register and qualified by a per-bit mask. The control register contents are supplied as levels by the surrounding register file. A strobe marks each write to the vertical control register. Software clears status bits by writing ones to them.

The vertical-blank tracker has three named states: ARMED (2'b00), PENDING (2'b01) and DISARMED (2'b10). It has four transitions:
- ARM_TO_PEND happens on a vertical-blank start.
- PEND_TO_DISARM happens on a write to the vertical control register with its enable bit clear.
- ARM_TO_DISARM happens when a vertical-blank start and such a write land in the same cycle.
- DISARM_TO_ARM happens on a write with the enable bit set.

Nothing else moves the tracker. In particular, a pending event is never simply dropped. Disabling parks it in DISARMED, and enabling again returns to ARMED rather than to PENDING. A readback flag mirrors bit 7 of the input status register seen by software.

Top module: `vbi_ctrl`

## Requirements
- R1: After reset the tracker is ARMED (`vb_state_o` = 2'b00), `status_o` is zero, `inta_o` is low and `vb_flag_o` is low.
- R2: A `vblank_start_i` pulse moves ARMED to PENDING on that clock edge, and has no effect on the tracker when it is DISARMED.
- R3: A vertical control write (`vctl_wr_i`) with enable bit 4 of `vctl_i` clear moves PENDING to DISARMED and leaves ARMED unchanged.
- R4: A vertical control write with bit 4 set moves DISARMED to ARMED and leaves PENDING unchanged. When a blank start and a write arrive together, the blank start is applied first and the write second.
- R5: Engine pulses set status bits one edge later: `fifo_empty_i` sets bit 1, `gfx_done_i` sets bit 2 and `gfx_fifo_empty_i` sets bit 6. A `stat_wr_i` write clears every bit where `stat_wdata_i` is 1. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: A blank start sets status bit 0 (vsync) when mask bit 0 is set. It also sets bit 0 when all of the following hold: `irq_ctl_i` bit 4 is set, `vctl_i` bit 5 is clear and the tracker is not DISARMED.
- R7: `inta_o` is registered. At each edge it takes the value of the following expression, evaluated with the state and status held before that edge: `irq_ctl_i[4]` AND (`(status & mask) != 0` OR (`vctl_i[5]` clear AND tracker PENDING)).
- R8: While `irq_ctl_i` bit 4 is clear, `inta_o` is low from the next edge on, whatever the status and tracker hold.
- R9: `vb_flag_o` is high exactly when the tracker is PENDING or status bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_start_i | input | 1 | One-cycle pulse at vertical blank start |
| fifo_empty_i | input | 1 | Pulse: command FIFO drained |
| gfx_done_i | input | 1 | Pulse: 3D render finished |
| gfx_fifo_empty_i | input | 1 | Pulse: 3D FIFO drained |
| vctl_i | input | 8 | Vertical control register contents (bit 4 enable, bit 5 block) |
| vctl_wr_i | input | 1 | Strobe: vertical control register written this cycle |
| irq_ctl_i | input | 8 | Interrupt control register contents (bit 4 master enable) |
| mask_i | input | 8 | Status interrupt mask |
| stat_wr_i | input | 1 | Strobe: write-one-to-clear of status |
| stat_wdata_i | input | 8 | Bits to clear in status |
| inta_o | output | 1 | Level interrupt request |
| status_o | output | 8 | Latched status bits |
| vb_flag_o | output | 1 | Input status bit 7 readback |
| vb_state_o | output | 2 | Tracker state |

## Verification
Tracker state, status bits and the readback flag change on the edge that samples a stimulus, so they are due at the falling edge that follows that edge. `inta_o` is registered once more from that state, so an event reaches it two edges after the stimulus. A level change on a control register reaches it one edge after the change. The bench drives inputs on falling edges and keeps a behavioural reference that is updated on every rising edge. On every falling edge it compares all four outputs with that reference. Directed checks with fixed expected values sample at the same falling edges.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
    // Vertical blank tracker states; encodings are visible on vb_state_o
    typedef enum logic [1:0] {
        VB_ARMED    = 2'b00,
        VB_PENDING  = 2'b01,
        VB_DISARMED = 2'b10
    } vb_state_e;
endpackage

// File: rtl/vbi_pend_fsm.sv
module vbi_pend_fsm
    import vbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vblank_i,
    input  logic      wr_i,
    input  logic      en_i,
    output vb_state_e state_o,
    output logic      pending_o,
    output logic      live_o
);
    vb_state_e state_q, state_d;
    logic      wr_off, wr_on;

    assign wr_off = wr_i & ~en_i;
    assign wr_on  = wr_i &  en_i;

    // next-state: blank start is applied first, the register write second
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VB_ARMED: begin
                if (vblank_i) state_d = wr_off ? VB_DISARMED : VB_PENDING;
            end
            VB_PENDING: begin
                if (wr_off) state_d = VB_DISARMED;
            end
            VB_DISARMED: begin
                if (wr_on) state_d = VB_ARMED;
            end
            default: state_d = VB_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VB_ARMED;
        else        state_q <= state_d;
    end

    // outputs decoded from the state register only
    always_comb begin
        state_o   = state_q;
        pending_o = 1'b0;
        live_o    = 1'b1;
        unique case (state_q)
            VB_ARMED:    begin pending_o = 1'b0; live_o = 1'b1; end
            VB_PENDING:  begin pending_o = 1'b1; live_o = 1'b1; end
            VB_DISARMED: begin pending_o = 1'b0; live_o = 1'b0; end
            default:     begin pending_o = 1'b0; live_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/vbi_status.sv
module vbi_status #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] clr_eff;

    assign clr_eff = clr_we_i ? clr_i : '0;

    // one flop per bit; a set in the same cycle as its clear wins
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_q[b] <= 1'b0;
            else if (set_i[b])   stat_q[b] <= 1'b1;
            else if (clr_eff[b]) stat_q[b] <= 1'b0;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/vbi_irq_merge.sv
module vbi_irq_merge #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_i,
    input  logic              vsync_block_i,
    input  logic              pending_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic              inta_o
);
    logic eng_hit, vs_hit, inta_q;

    assign eng_hit = master_en_i & (|(stat_i & mask_i));
    assign vs_hit  = master_en_i & ~vsync_block_i & pending_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inta_q <= 1'b0;
        else        inta_q <= eng_hit | vs_hit;
    end

    assign inta_o = inta_q;
endmodule

// File: rtl/vbi_ctrl.sv
module vbi_ctrl #(
    parameter int STAT_W    = 8,
    parameter int CTL_W     = 8,
    parameter int VSY_BIT   = 0,
    parameter int FIFO_BIT  = 1,
    parameter int DONE_BIT  = 2,
    parameter int GFIFO_BIT = 6,
    parameter int VEN_BIT   = 4,
    parameter int VBLK_BIT  = 5,
    parameter int IEN_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank_start_i,
    input  logic              fifo_empty_i,
    input  logic              gfx_done_i,
    input  logic              gfx_fifo_empty_i,
    input  logic [CTL_W-1:0]  vctl_i,
    input  logic              vctl_wr_i,
    input  logic [CTL_W-1:0]  irq_ctl_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    output logic              inta_o,
    output logic [STAT_W-1:0] status_o,
    output logic              vb_flag_o,
    output logic [1:0]        vb_state_o
);
    import vbi_pkg::*;

    localparam int NUM_ENG = 3;
    localparam int ENG_POS [NUM_ENG] = '{FIFO_BIT, DONE_BIT, GFIFO_BIT};

    vb_state_e         state;
    logic              pending, live;
    logic              master_en, vs_block;
    logic              vsy_set;
    logic [NUM_ENG-1:0] eng_evt;
    logic [STAT_W-1:0] set_vec;

    assign master_en = irq_ctl_i[IEN_BIT];
    assign vs_block  = vctl_i[VBLK_BIT];
    assign eng_evt   = {gfx_fifo_empty_i, gfx_done_i, fifo_empty_i};

    // vsync status: masked request, or vsync path open and tracker live
    assign vsy_set = vblank_start_i &
                     (mask_i[VSY_BIT] | (master_en & ~vs_block & live));

    always_comb begin
        set_vec          = '0;
        set_vec[VSY_BIT] = vsy_set;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (eng_evt[i]) set_vec[ENG_POS[i]] = 1'b1;
        end
    end

    vbi_pend_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank_i  (vblank_start_i),
        .wr_i      (vctl_wr_i),
        .en_i      (vctl_i[VEN_BIT]),
        .state_o   (state),
        .pending_o (pending),
        .live_o    (live)
    );

    vbi_status #(.STAT_W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we_i (stat_wr_i),
        .clr_i    (stat_wdata_i),
        .stat_o   (status_o)
    );

    vbi_irq_merge #(.STAT_W(STAT_W)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_en_i   (master_en),
        .vsync_block_i (vs_block),
        .pending_i     (pending),
        .stat_i        (status_o),
        .mask_i        (mask_i),
        .inta_o        (inta_o)
    );

    assign vb_flag_o  = pending | status_o[VSY_BIT];
    assign vb_state_o = state;
endmodule

// File: rtl/vbi_ctrl_chk.sv
module vbi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vblank_start_i,
    input logic       fifo_empty_i,
    input logic [7:0] vctl_i,
    input logic       vctl_wr_i,
    input logic [7:0] irq_ctl_i,
    input logic       inta_o,
    input logic [7:0] status_o,
    input logic       vb_flag_o,
    input logic [1:0] vb_state_o
);
    // R8
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ctl_i[4] |=> !inta_o);

    // R2
    disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_state_o == 2'b10 && !(vctl_wr_i && vctl_i[4])) |=> vb_state_o == 2'b10);

    // R3
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_state_o == 2'b01 && !(vctl_wr_i && !vctl_i[4])) |=> vb_state_o == 2'b01);

    // R5
    fifo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty_i |=> status_o[1]);

    // R9
    flag_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vb_state_o == 2'b01 |-> vb_flag_o);

    // R2
    arm_to_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_state_o == 2'b00 && vblank_start_i && !vctl_wr_i) |=> vb_state_o == 2'b01);
endmodule

bind vbi_ctrl vbi_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vblank_start_i (vblank_start_i),
    .fifo_empty_i   (fifo_empty_i),
    .vctl_i         (vctl_i),
    .vctl_wr_i      (vctl_wr_i),
    .irq_ctl_i      (irq_ctl_i),
    .inta_o         (inta_o),
    .status_o       (status_o),
    .vb_flag_o      (vb_flag_o),
    .vb_state_o     (vb_state_o)
);

// File: tb/vbi_ctrl_tb_top.sv
`timescale 1ns/1ps
module vbi_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vblank_start_i = 1'b0, fifo_empty_i = 1'b0, gfx_done_i = 1'b0, gfx_fifo_empty_i = 1'b0;
    logic [7:0] vctl_i = 8'h00, irq_ctl_i = 8'h00, mask_i = 8'h00, stat_wdata_i = 8'h00;
    logic       vctl_wr_i = 1'b0, stat_wr_i = 1'b0;
    logic       inta_o, vb_flag_o;
    logic [7:0] status_o;
    logic [1:0] vb_state_o;

    int errors = 0, checks = 0;
    bit finished = 0, live_cmp = 0;

    // reference model: -1 disarmed, 0 armed, 1 pending
    int         m_state = 0;
    logic [7:0] m_stat = 8'h00;
    logic       m_inta = 1'b0;

    always #2.5 clk = ~clk;

    vbi_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .vblank_start_i(vblank_start_i),
        .fifo_empty_i(fifo_empty_i), .gfx_done_i(gfx_done_i),
        .gfx_fifo_empty_i(gfx_fifo_empty_i), .vctl_i(vctl_i), .vctl_wr_i(vctl_wr_i),
        .irq_ctl_i(irq_ctl_i), .mask_i(mask_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .inta_o(inta_o), .status_o(status_o),
        .vb_flag_o(vb_flag_o), .vb_state_o(vb_state_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_stat = 8'h00; m_inta = 1'b0;
        end else begin
            int s;
            logic [7:0] sets, clrs;
            m_inta = irq_ctl_i[4] && (((m_stat & mask_i) != 0) || (!vctl_i[5] && m_state == 1));
            sets = 8'h00;
            if (vblank_start_i && (mask_i[0] || (irq_ctl_i[4] && !vctl_i[5] && m_state != -1)))
                sets[0] = 1'b1;
            if (fifo_empty_i)     sets[1] = 1'b1;
            if (gfx_done_i)       sets[2] = 1'b1;
            if (gfx_fifo_empty_i) sets[6] = 1'b1;
            clrs = stat_wr_i ? stat_wdata_i : 8'h00;
            m_stat = (m_stat & ~clrs) | sets;
            s = m_state;
            if (vblank_start_i && s != -1) s = 1;
            if (vctl_wr_i) begin
                if (!vctl_i[4] && s == 1) s = -1;
                else if (vctl_i[4] && s == -1) s = 0;
            end
            m_state = s;
        end
    end

    function automatic logic [1:0] enc(int s);
        return (s == 1) ? 2'b01 : (s == -1) ? 2'b10 : 2'b00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live_cmp && rst_n) begin
            chk("R2/R3/R4 state", {6'd0, vb_state_o}, {6'd0, enc(m_state)});
            chk("R5/R6 status", status_o, m_stat);
            chk("R7 inta", {7'd0, inta_o}, {7'd0, m_inta});
            chk("R9 flag", {7'd0, vb_flag_o}, {7'd0, (m_state == 1) || m_stat[0]});
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_vb();
        vblank_start_i = 1'b1; tick(); vblank_start_i = 1'b0;
    endtask

    task automatic wr_vctl(logic [7:0] v);
        vctl_i = v; vctl_wr_i = 1'b1; tick(); vctl_wr_i = 1'b0;
    endtask

    task automatic clr_stat(logic [7:0] v);
        stat_wdata_i = v; stat_wr_i = 1'b1; tick(); stat_wr_i = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        live_cmp = 1;
        tick();
        // R1 reset values
        chk("R1 state", {6'd0, vb_state_o}, 8'h00);
        chk("R1 status", status_o, 8'h00);
        chk("R1 inta", {7'd0, inta_o}, 8'h00);
        chk("R1 flag", {7'd0, vb_flag_o}, 8'h00);

        irq_ctl_i = 8'h10; vctl_i = 8'h10; mask_i = 8'h00; tick();
        pulse_vb();
        chk("R2 armed to pending", {6'd0, vb_state_o}, 8'h01);
        chk("R6 vsync status set", status_o, 8'h01);
        tick();
        chk("R7 vsync inta", {7'd0, inta_o}, 8'h01);

        wr_vctl(8'h00);
        chk("R3 pending to disarmed", {6'd0, vb_state_o}, 8'h02);
        tick();
        chk("R7 inta drops", {7'd0, inta_o}, 8'h00);
        chk("R9 flag from status", {7'd0, vb_flag_o}, 8'h01);
        clr_stat(8'h01);
        chk("R5 clear", status_o, 8'h00);
        chk("R9 flag clear", {7'd0, vb_flag_o}, 8'h00);

        pulse_vb();
        chk("R2 ignored when disarmed", {6'd0, vb_state_o}, 8'h02);
        chk("R6 no set when disarmed", status_o, 8'h00);

        wr_vctl(8'h10);
        chk("R4 disarmed to armed", {6'd0, vb_state_o}, 8'h00);

        vctl_i = 8'h30;
        pulse_vb();
        chk("R6 blocked by bit5", status_o, 8'h00);
        tick();
        chk("R7 blocked inta", {7'd0, inta_o}, 8'h00);
        vctl_i = 8'h10; tick();
        chk("R7 unblocked inta", {7'd0, inta_o}, 8'h01);
        irq_ctl_i = 8'h00; tick();
        chk("R8 master off", {7'd0, inta_o}, 8'h00);
        wr_vctl(8'h10);
        chk("R4 write with enable keeps pending", {6'd0, vb_state_o}, 8'h01);

        irq_ctl_i = 8'h10; wr_vctl(8'h00); mask_i = 8'h02;
        fifo_empty_i = 1'b1; tick(); fifo_empty_i = 1'b0;
        chk("R5 fifo bit", status_o, 8'h02);
        tick();
        chk("R7 engine inta", {7'd0, inta_o}, 8'h01);
        irq_ctl_i = 8'h00; tick();
        chk("R8 engine masked by master", {7'd0, inta_o}, 8'h00);
        irq_ctl_i = 8'h10;
        gfx_fifo_empty_i = 1'b1; gfx_done_i = 1'b1; tick();
        gfx_fifo_empty_i = 1'b0; gfx_done_i = 1'b0;
        chk("R5 gfx bits", status_o, 8'h46);
        fifo_empty_i = 1'b1; stat_wdata_i = 8'h02; stat_wr_i = 1'b1; tick();
        fifo_empty_i = 1'b0; stat_wr_i = 1'b0;
        chk("R5 set wins", status_o, 8'h46);
        clr_stat(8'h46);
        chk("R5 clear all", status_o, 8'h00);

        // same-cycle blank start and control writes
        vblank_start_i = 1'b1; vctl_i = 8'h10; vctl_wr_i = 1'b1; tick();
        chk("R4 disarmed plus blank", {6'd0, vb_state_o}, 8'h00);
        vctl_i = 8'h00; tick();
        vblank_start_i = 1'b0; vctl_wr_i = 1'b0;
        chk("R4 blank then disable", {6'd0, vb_state_o}, 8'h02);
        mask_i = 8'h01; pulse_vb();
        chk("R6 mask bit0 sets vsync", status_o, 8'h01);
        clr_stat(8'hff);

        // pseudo-random phase, checked by the per-cycle comparison
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                vblank_start_i   = (lf[3:0] == 4'h5);
                fifo_empty_i     = lf[4] & lf[5] & lf[6];
                gfx_done_i       = lf[7] & lf[8] & lf[9];
                gfx_fifo_empty_i = lf[10] & lf[11] & lf[1];
                vctl_wr_i        = (lf[15:13] == 3'b101);
                if (lf[2] & lf[12]) vctl_i = {2'b00, lf[9] & lf[3], lf[5], 4'h0};
                if (lf[0] & lf[14] & lf[6]) irq_ctl_i = {3'b000, ~lf[8] | lf[1], 4'h0};
                if (lf[15:11] == 5'h0b) mask_i = lf[7:0] & 8'h47;
                stat_wr_i        = (lf[11:9] == 3'b110);
                stat_wdata_i     = lf[8:1];
                tick();
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule